// File: doc/BRIEF.md
# Protected Power-of-Two Clock Prescaler

This block divides a source clock by a selectable power of two, from 1 to 256, and gives the result to downstream logic as a one-cycle tick. The tick is a clock enable in the source domain. Every flip-flop that uses it stays on the undivided clock, and the counter that makes it also runs on that clock. A tick that is high for one source cycle in every N cycles is equivalent to a clock divided by N. Because it comes straight from registers, it cannot glitch.

A single 8-bit register sets the division. Bit 7 is the change-enable flag and bits 3:0 hold the division code. Changing the ratio needs two steps. First, a write of exactly 0x80 opens a short window. Second, a write with bit 7 clear, made inside that window, supplies the new code. A static strap input chooses the code that reset loads: either divide-by-1 or divide-by-8.

A new ratio never cuts the current period short. The period that is running completes at the old ratio. The interval that starts after the next tick uses the new ratio. As a result, no tick interval during a switch is shorter than the smaller of the old and new periods.

Top module: `pscl_prescaler`

## Requirements
- R1: While reset is high, the readback becomes 0x03 (code 3, divide by 8) if the strap is high, and 0x00 (code 0, divide by 1) if it is low. In both cases the flag is clear. After reset, the first tick comes 2^code source cycles after reset is released, counting the first cycle after release as cycle 1.
- R2: Code k, for k from 0 to 8, gives a tick high for exactly one source cycle in every 2^k source cycles.
- R3: The flag (readback bit 7) is set only by a write of exactly 0x80 made while the flag is clear. Any other write made while the flag is clear, including 0x81, leaves the flag clear.
- R4: Once set, the flag stays high for exactly 4 source cycles and then clears. The 4 cycles are the 4 write opportunities after the unlocking write. While the flag is high, a write with bit 7 set neither extends the window nor clears the flag.
- R5: While the flag is high, a write with bit 7 clear loads data bits 3:0 as the new code and clears the flag. The readback shows the new code one cycle after the write.
- R6: A write with bit 7 clear while the flag is clear changes nothing.
- R7: Codes 9 to 15 are reserved. Writing one inside the window leaves the previous code and ratio in effect, but still clears the flag.
- R8: Readback bits 6:4 always read as zero, even after a code write whose bits 6:4 were nonzero.
- R9: A new code first governs the tick interval that begins after the first tick falling in the write cycle or any later cycle. Until that tick, the old ratio governs. So no interval is shorter than the smaller of the old and new periods.
- R10: With code 0, the tick is high on every source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_i | input | 1 | Synchronous reset, active high |
| boot_slow_i | input | 1 | Strap that selects divide-by-8 at reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Readback: flag in bit 7, code in bits 3:0 |
| tick_o | output | 1 | Divided-clock enable, one source cycle wide |

## Verification
The assertions check the following on every cycle:
- the flag rises only after a 0x80 write;
- the flag stays high for no more than four cycles;
- a code write drops the flag;
- the code changes only through a windowed write;
- the code held is never reserved;
- the code loaded at reset follows the strap;
- tick spacing never exceeds the slowest ratio.

Only the bench scenarios can show some behaviours:
- how far the old ratio runs past a write before the new one takes over;
- that a second unlock does not lengthen the window;
- that a late code write is refused;
- the exact tick period for each code.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    localparam int REG_W      = 8;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 8;
    localparam int CNT_W      = MAX_CODE;
    localparam int UNLOCK_BIT = REG_W - 1;
    localparam int WIN_LEN    = 4;
    localparam int BOOT_SLOW  = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_UNLOCK,
        WR_CODE,
        WR_DROP
    } wr_kind_e;

    typedef struct packed {
        logic valid;
        cnt_t lim;
    } pend_s;

    function automatic logic code_legal(input code_t c);
        return c <= code_t'(MAX_CODE);
    endfunction

    // 2^c - 1 is a run of c ones
    function automatic cnt_t code_to_lim(input code_t c);
        cnt_t r;
        r = '0;
        for (int i = 0; i < CNT_W; i++) begin
            r[i] = (i < int'(c));
        end
        return r;
    endfunction

    function automatic code_t boot_code(input logic slow);
        return slow ? code_t'(BOOT_SLOW) : code_t'(0);
    endfunction

    function automatic logic is_unlock(input reg_t d);
        return d == (reg_t'(1) << UNLOCK_BIT);
    endfunction

endpackage

// File: rtl/pscl_write_guard.sv
module pscl_write_guard
    import pscl_pkg::*;
#(
    parameter int WIN = WIN_LEN
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  boot_slow_i,
    input  logic  wr_en_i,
    input  reg_t  wr_data_i,
    output logic  ce_o,
    output code_t code_o,
    output logic  load_o,
    output code_t load_code_o
);

    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic            ce_q;
    logic [WIN_W-1:0] win_q;
    code_t           code_q;
    wr_kind_e        kind;
    code_t           wr_code;
    logic            wr_legal;

    assign wr_code  = wr_data_i[CODE_W-1:0];
    assign wr_legal = code_legal(wr_code);

    always_comb begin
        if (!wr_en_i) begin
            kind = WR_NONE;
        end else if (!ce_q && is_unlock(wr_data_i)) begin
            kind = WR_UNLOCK;
        end else if (ce_q && !wr_data_i[UNLOCK_BIT]) begin
            kind = WR_CODE;
        end else begin
            kind = WR_DROP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ce_q   <= 1'b0;
            win_q  <= '0;
            code_q <= boot_code(boot_slow_i);
        end else if (kind == WR_UNLOCK) begin
            ce_q  <= 1'b1;
            win_q <= WIN_W'(WIN - 1);
        end else if (kind == WR_CODE) begin
            ce_q <= 1'b0;
            if (wr_legal) begin
                code_q <= wr_code;
            end
        end else if (ce_q) begin
            if (win_q == '0) begin
                ce_q <= 1'b0;
            end else begin
                win_q <= win_q - 1'b1;
            end
        end
    end

    assign ce_o        = ce_q;
    assign code_o      = code_q;
    assign load_o      = (kind == WR_CODE) && wr_legal;
    assign load_code_o = wr_code;

endmodule

// File: rtl/pscl_tick_gen.sv
module pscl_tick_gen
    import pscl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  cnt_t boot_lim_i,
    input  logic load_i,
    input  cnt_t load_lim_i,
    output logic tick_o
);

    cnt_t  cnt_q;
    cnt_t  lim_q;
    pend_s pend_q;
    pend_s pend_n;
    logic  tick;

    assign tick = (cnt_q == lim_q);

    // a code accepted this cycle is visible to this cycle's boundary
    always_comb begin
        if (load_i) begin
            pend_n.valid = 1'b1;
            pend_n.lim   = load_lim_i;
        end else begin
            pend_n = pend_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            lim_q  <= boot_lim_i;
            pend_q <= '0;
        end else if (tick) begin
            cnt_q  <= '0;
            pend_q <= '0;
            if (pend_n.valid) begin
                lim_q <= pend_n.lim;
            end
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= pend_n;
        end
    end

    assign tick_o = tick;

endmodule

// File: rtl/pscl_prescaler.sv
module pscl_prescaler
    import pscl_pkg::*;
#(
    parameter int WIN = WIN_LEN
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             boot_slow_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             tick_o
);

    logic  ce;
    code_t code;
    logic  load;
    code_t load_code;
    reg_t  rd;

    pscl_write_guard #(.WIN(WIN)) u_guard (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .boot_slow_i (boot_slow_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .ce_o        (ce),
        .code_o      (code),
        .load_o      (load),
        .load_code_o (load_code)
    );

    pscl_tick_gen u_tick (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .boot_lim_i (code_to_lim(boot_code(boot_slow_i))),
        .load_i     (load),
        .load_lim_i (code_to_lim(load_code)),
        .tick_o     (tick_o)
    );

    always_comb begin
        rd                 = '0;
        rd[UNLOCK_BIT]     = ce;
        rd[CODE_W-1:0]     = code;
    end

    assign rd_data_o = rd;

endmodule

// File: rtl/pscl_prescaler_chk.sv
module pscl_prescaler_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       boot_slow_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       tick_o
);

    logic [7:0] ce_run;
    logic [8:0] gap;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ce_run <= '0;
            gap    <= '0;
        end else begin
            ce_run <= rd_data_o[7] ? ce_run + 8'd1 : 8'd0;
            gap    <= tick_o ? 9'd0 : gap + 9'd1;
        end
    end

    a_r1_boot_code: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> rd_data_o[3:0] == ($past(boot_slow_i) ? 4'd3 : 4'd0));

    a_r7_code_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[3:0] <= 4'd8);

    a_r3_unlock_source: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rd_data_o[7]) |-> $past(wr_en_i && wr_data_i == 8'h80));

    a_r4_window_cap: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[7] |-> ce_run < 8'd4);

    a_r5_code_closes: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rd_data_o[7] && wr_en_i && !wr_data_i[7]) |-> !rd_data_o[7]);

    a_r6_code_guard: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && rd_data_o[3:0] != $past(rd_data_o[3:0]))
            |-> $past(rd_data_o[7] && wr_en_i && !wr_data_i[7]));

    a_r2_gap_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        gap < 9'd256);

endmodule

bind pscl_prescaler pscl_prescaler_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .boot_slow_i (boot_slow_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .tick_o      (tick_o)
);

// File: tb/pscl_prescaler_test.sv
`timescale 1ns/1ps
module pscl_prescaler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_slow = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string phase_req = "R1";

    // behavioural reference state
    int mcode, mper, mcnt, mpend_per, mwin;
    bit mpend, mce;

    pscl_prescaler uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .boot_slow_i (boot_slow),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_data_o   (rd_data),
        .tick_o      (tick)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        bit t;
        bit cur;
        cycles++;
        if (rst) begin
            mcode = boot_slow ? 3 : 0;
            mper  = 1 << mcode;
            mcnt  = 0;
            mpend = 0;
            mce   = 0;
            mwin  = 0;
        end else begin
            t   = (mcnt == mper - 1);
            cur = mce;
            if (wr_en && !cur && wr_data == 8'h80) begin
                mce  = 1;
                mwin = 3;
            end else if (wr_en && cur && !wr_data[7]) begin
                mce = 0;
                if (int'(wr_data[3:0]) <= 8) begin
                    mcode     = int'(wr_data[3:0]);
                    mpend     = 1;
                    mpend_per = 1 << mcode;
                end
            end else if (cur) begin
                if (mwin == 0) mce = 0;
                else mwin--;
            end
            if (t) begin
                mcnt = 0;
                if (mpend) begin
                    mper  = mpend_per;
                    mpend = 0;
                end
            end else begin
                mcnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            logic [7:0] exp_rd;
            exp_rd = {mce, 3'b000, 4'(mcode)};
            chk(tick === (mcnt == mper - 1), phase_req, "tick", int'(tick),
                int'(mcnt == mper - 1));
            chk(rd_data === exp_rd, phase_req, "readback", int'(rd_data),
                int'(exp_rd));
        end
    end

    always @(negedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tick();
        while (tick !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(input string req, input int exp);
        int n;
        wait_tick();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tick !== 1'b1 && n < 1000);
        chk(n == exp, req, "tick period", n, exp);
    endtask

    initial begin
        // R1: slow strap
        boot_slow = 1'b1;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        chk(rd_data == 8'h03, "R1", "boot readback slow", int'(rd_data), 3);
        measure("R2", 8);

        // R3, R5, R10: unlock then code 0
        phase_req = "R3";
        wr(8'h80);
        chk(rd_data == 8'h83, "R3", "flag after unlock", int'(rd_data), 8'h83);
        phase_req = "R5";
        wr(8'h00);
        chk(rd_data == 8'h00, "R5", "code loaded", int'(rd_data), 0);
        phase_req = "R10";
        measure("R10", 1);

        // R2: code 2 and code 5
        phase_req = "R2";
        wr(8'h80); wr(8'h02);
        idle(6);
        measure("R2", 4);
        wr(8'h80); wr(8'h05);
        idle(40);
        measure("R2", 32);

        // R3: near-miss unlock, then code write must be ignored
        phase_req = "R3";
        wr(8'h81);
        chk(rd_data[7] == 1'b0, "R3", "flag after 0x81", int'(rd_data[7]), 0);
        wr(8'h01);
        chk(rd_data == 8'h05, "R3", "code after bad unlock", int'(rd_data), 5);

        // R6: code write without unlock
        phase_req = "R6";
        wr(8'h02);
        chk(rd_data == 8'h05, "R6", "code after unguarded write",
            int'(rd_data), 5);

        // R4: last opportunity accepted
        phase_req = "R4";
        wr(8'h80); idle(3); wr(8'h04);
        chk(rd_data == 8'h04, "R4", "fourth-slot write", int'(rd_data), 4);
        // R4: fifth slot refused
        wr(8'h80); idle(4);
        chk(rd_data[7] == 1'b0, "R4", "flag expired", int'(rd_data[7]), 0);
        wr(8'h05);
        chk(rd_data == 8'h04, "R4", "late write", int'(rd_data), 4);
        // R4: re-unlock does not extend
        wr(8'h80); idle(1); wr(8'h80);
        chk(rd_data[7] == 1'b1, "R4", "flag kept by re-unlock",
            int'(rd_data[7]), 1);
        idle(2); wr(8'h06);
        chk(rd_data == 8'h04, "R4", "no window extension", int'(rd_data), 4);

        // R7: reserved code
        phase_req = "R7";
        wr(8'h80); wr(8'h0C);
        chk(rd_data == 8'h04, "R7", "reserved code ignored", int'(rd_data), 4);
        measure("R7", 16);

        // R8: reserved bits stay zero
        phase_req = "R8";
        wr(8'h80); wr(8'h71);
        chk(rd_data == 8'h01, "R8", "bits 6:4 zero", int'(rd_data), 1);
        measure("R8", 2);

        // R9: slow to fast, old period must complete
        phase_req = "R9";
        wr(8'h80); wr(8'h08);
        idle(300);
        wait_tick();
        idle(10);
        wr(8'h80); wr(8'h00);
        begin
            int seen;
            seen = 0;
            repeat (200) begin
                if (tick === 1'b1) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R9", "old ratio kept", seen, 0);
        end
        wait_tick();
        @(negedge clk);
        chk(tick === 1'b1, "R9", "new ratio after boundary", int'(tick), 1);
        // fast to slow: applies at the boundary in the write cycle
        wr(8'h80); wr(8'h08);
        measure("R9", 256);

        // R1: fast strap
        phase_req = "R1";
        boot_slow = 1'b0;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        chk(rd_data == 8'h00, "R1", "boot readback fast", int'(rd_data), 0);
        chk(tick === 1'b1, "R1", "first tick fast", int'(tick), 1);
        idle(10);

        done = 1'b1;
        finish_run();
    end

endmodule